// File: doc/BRIEF.md
# Priority Interrupt Acceptance Arbiter

This block sits beside a processor core and decides which interrupt, if any, the core should take next. Requests arrive as a vector, a three-bit delivery mode and a level/edge flag. Ordinary requests are queued in a 256-entry request array. Four special kinds each keep a single pending flag and one stored vector: system-management, non-maskable, init and external. The block tells the core whether anything is pending and presents the vector and kind it would service. It updates its arrays when the core acknowledges the interrupt or signals end of interrupt.

Ordinary vectors compete on priority class, which is the upper nibble of the vector. A class must beat the task-priority class. The highest requested vector must also be above the highest vector already in service. The system-management, non-maskable and init kinds ignore both the enable input and the task priority, and are served in a fixed order. All outputs are combinational from the stored state and the current enable and task-priority inputs. State changes on the rising clock edge. Reset is synchronous and active low.

Top module: `irq_accept_arb`

## Requirements
- R1: While reset is held, all arrays and pending flags clear. In the first cycle after release, intPending is 0, svcKind is 0 (none) and svcVector is 0.
- R2: Mode 0 (fixed) and mode 1 (lowest priority) set the vector's request bit. If that bit was clear, the trigger bit takes reqLevel; a repeat request for a set bit leaves the trigger bit unchanged. svcLevel shows the trigger bit of a presented ordinary vector and is 0 otherwise.
- R3: Modes 2 (system management), 4 (non-maskable), 5 (init) and 7 (external) each set one pending flag and store the vector. A request whose flag is already set is dropped, and the stored vector is kept.
- R4: Modes 3 and 6 are reserved, and a request carrying either changes no state.
- R5: A pending system-management, non-maskable or init request drives intPending high whatever intrEnable is.
- R6: A pending external request is presented only while intrEnable is 1.
- R7: An ordinary vector is presented only when three conditions hold: intrEnable is 1, the highest requested vector is above the highest in-service vector, and its bits 7:4 exceed taskPriority bits 7:4.
- R8: Presentation order is system management, then non-maskable, then init, then external, then ordinary. svcKind codes are 1, 2, 3, 4 and 5 in that order, and 0 means none, with svcVector 0. An acknowledge clears only the item presented.
- R9: Acknowledging an ordinary vector moves its bit from the request array to the in-service array. Lower vectors are then held back.
- R10: End of interrupt clears the highest in-service bit, after which held-back vectors can be presented again.
- R11: An acknowledge while intPending is 0 changes no state.
- R12: A request is judged against the state before the clock edge. A request for a vector whose request bit is being acknowledged in the same cycle is therefore dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| reqValid | input | 1 | Incoming request strobe |
| reqVector | input | 8 | Request vector |
| reqMode | input | 3 | Request delivery mode |
| reqLevel | input | 1 | 1 = level, 0 = edge |
| intrEnable | input | 1 | Core interrupt-enable flag |
| taskPriority | input | 8 | Task priority; bits 7:4 are compared |
| ack | input | 1 | Core takes the presented interrupt |
| eoi | input | 1 | End of interrupt for highest in-service vector |
| intPending | output | 1 | Something is presented |
| svcVector | output | 8 | Presented vector |
| svcKind | output | 3 | Presented kind (0 none … 5 ordinary) |
| svcLevel | output | 1 | Trigger bit of a presented ordinary vector |

## Verification
A wrong bit in the request or in-service array shows up at the ports in one of two ways. A vector may be presented that was never requested, or a lower vector may be presented or held back at the wrong time. Either appears in the cycle right after the acknowledge or end of interrupt that exposes the bit. A stuck or lost special flag changes svcKind in the first cycle the service order reaches it. Comparing every output with a behavioural model on every cycle catches each of these at the first cycle they become visible.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  typedef enum logic [2:0] {
    KIND_NONE  = 3'd0,
    KIND_SMI   = 3'd1,
    KIND_NMI   = 3'd2,
    KIND_INIT  = 3'd3,
    KIND_EXT   = 3'd4,
    KIND_FIXED = 3'd5
  } svcKind_e;

  localparam logic [2:0] MODE_FIXED  = 3'd0;
  localparam logic [2:0] MODE_LOWEST = 3'd1;
  localparam logic [2:0] MODE_SMI    = 3'd2;
  localparam logic [2:0] MODE_NMI    = 3'd4;
  localparam logic [2:0] MODE_INIT   = 3'd5;
  localparam logic [2:0] MODE_EXT    = 3'd7;

  // special slot index doubles as service order
  localparam int SPEC_N    = 4;
  localparam int SPEC_SMI  = 0;
  localparam int SPEC_NMI  = 1;
  localparam int SPEC_INIT = 2;
  localparam int SPEC_EXT  = 3;

  typedef struct packed {
    logic              setReq;
    logic [SPEC_N-1:0] setSpec;
    logic              ackReg;
    logic [SPEC_N-1:0] clrSpec;
    logic              eoi;
  } arbStrobe_t;

endpackage

// File: rtl/irq_top_bit.sv
module irq_top_bit #(
  parameter int N = 256,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] vecBits,
  output logic [W-1:0] top
);
  // highest set index; zero when nothing is set
  always_comb begin
    top = '0;
    for (int i = 0; i < N; i++) begin
      if (vecBits[i]) top = W'(i);
    end
  end
endmodule

// File: rtl/irq_arb_dp.sv
module irq_arb_dp
  import irq_arb_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  arbStrobe_t                    strobe,
  input  logic [VEC_W-1:0]              reqVector,
  input  logic                          reqLevel,
  output logic [VEC_W-1:0]              irrTop,
  output logic [VEC_W-1:0]              isrTop,
  output logic                          topLevel,
  output logic [SPEC_N-1:0]             specPend,
  output logic [SPEC_N-1:0][VEC_W-1:0]  specVec
);
  localparam int NUM_VEC = 1 << VEC_W;
  localparam logic [NUM_VEC-1:0] ONE = NUM_VEC'(1);

  logic [NUM_VEC-1:0] irr, isr, tmr;
  logic [NUM_VEC-1:0] reqMask, ackMask, eoiMask;
  logic reqFresh;

  irq_top_bit #(.N(NUM_VEC), .W(VEC_W)) u_irrEnc (.vecBits(irr), .top(irrTop));
  irq_top_bit #(.N(NUM_VEC), .W(VEC_W)) u_isrEnc (.vecBits(isr), .top(isrTop));

  assign reqFresh = strobe.setReq && !irr[reqVector];
  assign reqMask  = reqFresh ? (ONE << reqVector) : '0;
  assign ackMask  = strobe.ackReg ? (ONE << irrTop) : '0;
  assign eoiMask  = strobe.eoi ? (ONE << isrTop) : '0;
  assign topLevel = tmr[irrTop];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irr <= '0;
      isr <= '0;
      tmr <= '0;
    end else begin
      irr <= (irr & ~ackMask) | reqMask;
      isr <= (isr & ~eoiMask) | ackMask;
      if (reqFresh) tmr[reqVector] <= reqLevel;
    end
  end

  for (genvar k = 0; k < SPEC_N; k++) begin : g_spec
    always_ff @(posedge clk) begin
      if (!rstN) begin
        specPend[k] <= 1'b0;
        specVec[k]  <= '0;
      end else if (strobe.clrSpec[k]) begin
        specPend[k] <= 1'b0;
      end else if (strobe.setSpec[k]) begin
        specPend[k] <= 1'b1;
        specVec[k]  <= reqVector;
      end
    end
  end
endmodule

// File: rtl/irq_arb_ctrl.sv
module irq_arb_ctrl
  import irq_arb_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic                          reqValid,
  input  logic [2:0]                    reqMode,
  input  logic                          intrEnable,
  input  logic [VEC_W-1:0]              taskPriority,
  input  logic                          ack,
  input  logic                          eoi,
  input  logic [VEC_W-1:0]              irrTop,
  input  logic [VEC_W-1:0]              isrTop,
  input  logic                          topLevel,
  input  logic [SPEC_N-1:0]             specPend,
  input  logic [SPEC_N-1:0][VEC_W-1:0]  specVec,
  output arbStrobe_t                    strobe,
  output logic                          intPending,
  output logic [VEC_W-1:0]              svcVector,
  output svcKind_e                      svcKind,
  output logic                          svcLevel
);
  localparam int CLS_LO = VEC_W - 4;

  logic regularOk, take;
  logic [SPEC_N-1:0] modeHit;

  assign regularOk = intrEnable && (irrTop > isrTop) &&
                     (irrTop[VEC_W-1:CLS_LO] > taskPriority[VEC_W-1:CLS_LO]);

  always_comb begin
    svcKind   = KIND_NONE;
    svcVector = '0;
    if (specPend[SPEC_SMI]) begin
      svcKind = KIND_SMI;   svcVector = specVec[SPEC_SMI];
    end else if (specPend[SPEC_NMI]) begin
      svcKind = KIND_NMI;   svcVector = specVec[SPEC_NMI];
    end else if (specPend[SPEC_INIT]) begin
      svcKind = KIND_INIT;  svcVector = specVec[SPEC_INIT];
    end else if (intrEnable && specPend[SPEC_EXT]) begin
      svcKind = KIND_EXT;   svcVector = specVec[SPEC_EXT];
    end else if (regularOk) begin
      svcKind = KIND_FIXED; svcVector = irrTop;
    end
  end

  assign intPending = (svcKind != KIND_NONE);
  assign svcLevel   = (svcKind == KIND_FIXED) && topLevel;
  assign take       = ack && intPending;

  always_comb begin
    modeHit = '0;
    case (reqMode)
      MODE_SMI:  modeHit[SPEC_SMI]  = 1'b1;
      MODE_NMI:  modeHit[SPEC_NMI]  = 1'b1;
      MODE_INIT: modeHit[SPEC_INIT] = 1'b1;
      MODE_EXT:  modeHit[SPEC_EXT]  = 1'b1;
      default:   modeHit = '0;
    endcase
  end

  always_comb begin
    strobe         = '0;
    strobe.setReq  = reqValid && (reqMode == MODE_FIXED || reqMode == MODE_LOWEST);
    strobe.setSpec = (reqValid ? modeHit : '0) & ~specPend;
    strobe.ackReg  = take && (svcKind == KIND_FIXED);
    strobe.clrSpec[SPEC_SMI]  = take && (svcKind == KIND_SMI);
    strobe.clrSpec[SPEC_NMI]  = take && (svcKind == KIND_NMI);
    strobe.clrSpec[SPEC_INIT] = take && (svcKind == KIND_INIT);
    strobe.clrSpec[SPEC_EXT]  = take && (svcKind == KIND_EXT);
    strobe.eoi     = eoi;
  end
endmodule

// File: rtl/irq_accept_arb.sv
module irq_accept_arb
  import irq_arb_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [VEC_W-1:0] reqVector,
  input  logic [2:0]       reqMode,
  input  logic             reqLevel,
  input  logic             intrEnable,
  input  logic [VEC_W-1:0] taskPriority,
  input  logic             ack,
  input  logic             eoi,
  output logic             intPending,
  output logic [VEC_W-1:0] svcVector,
  output logic [2:0]       svcKind,
  output logic             svcLevel
);
  arbStrobe_t                   strobe;
  logic [VEC_W-1:0]             irrTop, isrTop;
  logic                         topLevel;
  logic [SPEC_N-1:0]            specPend;
  logic [SPEC_N-1:0][VEC_W-1:0] specVec;
  svcKind_e                     kindSel;

  irq_arb_dp #(.VEC_W(VEC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqVector(reqVector), .reqLevel(reqLevel),
    .irrTop(irrTop), .isrTop(isrTop), .topLevel(topLevel),
    .specPend(specPend), .specVec(specVec)
  );

  irq_arb_ctrl #(.VEC_W(VEC_W)) u_ctrl (
    .reqValid(reqValid), .reqMode(reqMode), .intrEnable(intrEnable),
    .taskPriority(taskPriority), .ack(ack), .eoi(eoi),
    .irrTop(irrTop), .isrTop(isrTop), .topLevel(topLevel),
    .specPend(specPend), .specVec(specVec), .strobe(strobe),
    .intPending(intPending), .svcVector(svcVector),
    .svcKind(kindSel), .svcLevel(svcLevel)
  );

  assign svcKind = kindSel;
endmodule

// File: rtl/irq_accept_arb_chk.sv
module irq_accept_arb_chk #(
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic [VEC_W-1:0] reqVector,
  input logic [2:0]       reqMode,
  input logic             reqLevel,
  input logic             intrEnable,
  input logic [VEC_W-1:0] taskPriority,
  input logic             ack,
  input logic             eoi,
  input logic             intPending,
  input logic [VEC_W-1:0] svcVector,
  input logic [2:0]       svcKind,
  input logic             svcLevel
);
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!intPending && svcKind == 3'd0 && svcVector == '0));

  assert_unmaskable_R5: assert property (@(posedge clk) disable iff (!rstN)
    (svcKind == 3'd1 || svcKind == 3'd2 || svcKind == 3'd3) |-> intPending);

  assert_ext_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    (svcKind == 3'd4) |-> (intrEnable && intPending));

  assert_class_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    (svcKind == 3'd5) |-> (intrEnable && svcVector[VEC_W-1:VEC_W-4] > taskPriority[VEC_W-1:VEC_W-4]));

  assert_smi_cleared_R8: assert property (@(posedge clk) disable iff (!rstN)
    (svcKind == 3'd1 && ack) |=> (svcKind != 3'd1));

  assert_none_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (svcKind == 3'd0) |-> (!intPending && svcVector == '0 && !svcLevel));

  // these inputs are observed only to keep the bound port list complete
  logic unusedSink;
  assign unusedSink = ^{reqValid, reqVector, reqMode, reqLevel, eoi};
endmodule

bind irq_accept_arb irq_accept_arb_chk #(.VEC_W(VEC_W)) u_chk (.*);

// File: tb/irq_accept_arb_tb.sv
module irq_accept_arb_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [7:0] reqVector = '0;
  logic [2:0] reqMode = '0;
  logic       reqLevel = 1'b0;
  logic       intrEnable = 1'b0;
  logic [7:0] taskPriority = '0;
  logic       ack = 1'b0;
  logic       eoi = 1'b0;
  logic       intPending;
  logic [7:0] svcVector;
  logic [2:0] svcKind;
  logic       svcLevel;

  int checks = 0;
  int errors = 0;
  bit nIe = 0;
  int nTpr = 0;

  // behavioural reference state
  bit [255:0] mIrr, mIsr, mTmr;
  bit [3:0]   mPend;
  int         mVec [4];

  irq_accept_arb u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVector(reqVector),
    .reqMode(reqMode), .reqLevel(reqLevel), .intrEnable(intrEnable),
    .taskPriority(taskPriority), .ack(ack), .eoi(eoi),
    .intPending(intPending), .svcVector(svcVector), .svcKind(svcKind),
    .svcLevel(svcLevel)
  );

  always #5ns clk = ~clk;

  function automatic int topOf(bit [255:0] a);
    int t = 0;
    for (int i = 0; i < 256; i++) if (a[i]) t = i;
    return t;
  endfunction

  task automatic cmp(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic cyc(string tag, bit rv = 0, int mode = 0, int vec = 0,
                     bit lvl = 0, bit a = 0, bit e = 0);
    int it, st, k, v, idx;
    bit regOk, pend, take, fresh;
    @(negedge clk);
    reqValid = rv; reqMode = 3'(mode); reqVector = 8'(vec); reqLevel = lvl;
    ack = a; eoi = e; intrEnable = nIe; taskPriority = 8'(nTpr);
    #1ns;
    it = topOf(mIrr); st = topOf(mIsr);
    regOk = nIe && it > st && (it >> 4) > (nTpr >> 4);
    if (mPend[0])            begin k = 1; v = mVec[0]; end
    else if (mPend[1])       begin k = 2; v = mVec[1]; end
    else if (mPend[2])       begin k = 3; v = mVec[2]; end
    else if (nIe && mPend[3]) begin k = 4; v = mVec[3]; end
    else if (regOk)          begin k = 5; v = it; end
    else                     begin k = 0; v = 0; end
    pend = (k != 0);
    cmp(tag, "intPending", int'(intPending), int'(pend));
    cmp(tag, "svcKind", int'(svcKind), k);
    cmp(tag, "svcVector", int'(svcVector), v);
    cmp(tag, "svcLevel", int'(svcLevel), (k == 5) ? int'(mTmr[it]) : 0);
    @(posedge clk);
    take  = a && pend;
    fresh = rv && (mode == 0 || mode == 1) && !mIrr[vec];
    case (mode)
      2: idx = 0; 4: idx = 1; 5: idx = 2; 7: idx = 3; default: idx = -1;
    endcase
    if (take && k >= 1 && k <= 4) mPend[k-1] = 0;
    if (e) mIsr[st] = 0;
    if (take && k == 5) begin mIrr[it] = 0; mIsr[it] = 1; end
    if (fresh) begin mIrr[vec] = 1; mTmr[vec] = lvl; end
    if (rv && idx >= 0 && !mPend[idx] && !(take && k == idx + 1)) begin
      mPend[idx] = 1; mVec[idx] = vec;
    end
  endtask

  initial begin
    #2ms;
    errors++;
    $display("FAIL watchdog R1 actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    mIrr = '0; mIsr = '0; mTmr = '0; mPend = '0;
    for (int i = 0; i < 4; i++) mVec[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    cyc("R1");
    // ordinary requests and trigger capture
    nIe = 1; nTpr = 0;
    cyc("R2", 1, 0, 'h35, 1);
    cyc("R2");
    cyc("R2", 1, 1, 'h52, 0);
    cyc("R2", 1, 0, 'h52, 1);   // repeat: trigger stays edge
    cyc("R2");
    // task priority gating
    nTpr = 'h60; cyc("R7"); cyc("R7");
    nTpr = 'h50; cyc("R7");     // equal class blocked
    nTpr = 'h40; cyc("R7");
    nIe = 0;    cyc("R7");
    nIe = 1;    cyc("R7");
    // acknowledge and end of interrupt
    cyc("R9", .a(1));
    cyc("R9"); cyc("R9");
    cyc("R10", .e(1));
    cyc("R10");
    cyc("R9", .a(1));
    cyc("R10", .e(1));
    cyc("R10");
    // reserved modes
    cyc("R4", 1, 3, 'h90, 1);
    cyc("R4", 1, 6, 'h91, 0);
    cyc("R4");
    // special kinds with interrupts disabled
    nIe = 0; nTpr = 0;
    cyc("R3", 1, 5, 'h11);
    cyc("R3", 1, 7, 'h22);
    cyc("R3", 1, 4, 'h33);
    cyc("R3", 1, 2, 'h44);
    cyc("R3", 1, 4, 'h55);      // dropped duplicate
    cyc("R3", 1, 0, 'hA0, 1);
    cyc("R5");
    cyc("R8", .a(1));
    cyc("R8", .a(1));
    cyc("R8", .a(1));
    cyc("R6");
    cyc("R11", .a(1));
    cyc("R11");
    nIe = 1; cyc("R6");
    cyc("R8", .a(1));
    cyc("R8");
    // same-cycle acknowledge and request of the same vector
    cyc("R12", 1, 0, 'hA0, 0, 1);
    cyc("R12");
    cyc("R12", 1, 1, 'hA0, 0);
    cyc("R12");
    cyc("R10", .e(1));
    cyc("R12");
    cyc("R12", 1, 2, 'h66, 0, 1);  // special request while ordinary acked
    cyc("R8");
    cyc("R8", .a(1));
    cyc("R8");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule